// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller of a single-issue processor that dispatches to several functional units. Each unit is a slot in a table. The slot records whether the unit is occupied, which register the unit will write, which two registers it reads, and which units, if any, still owe it those operands. A second table holds one entry per architectural register. The entry names the unit that will produce the register's next value, or holds a null code when no write is pending.

Every instruction passes four gates in order. The first is issue, which happens in program order. The second is operand read. The third is completion of execution, which the functional unit signals with a pulse. The last is result write. The decoder presents a decoded instruction with a destination, two sources and a target unit. The block answers with an issue stall, a per-unit operand read grant and a per-unit result write grant. Issue waits on structural and write-after-write hazards. Result write waits on write-after-read hazards. No operand is forwarded and no register is renamed. The opcode travels with the instruction inside the functional unit, so the block never sees it.

Top module: `sb_scoreboard`

## Requirements
- R1: `iss_stall` is high while `iss_valid` is high and the target unit `iss_fu` is occupied. This includes the cycle in which that unit is granted its result write. An instruction is accepted in a cycle where `iss_valid` is high and `iss_stall` is low.
- R2: `iss_stall` is high while `iss_valid` is high and `iss_dst` already has a pending producer. The stall ends in the cycle after that producer's write grant.
- R3: An accepted instruction claims its unit and records `iss_dst` as pending on that unit. Each source counts as ready if it has no pending producer, or if its producer is granted its write in the issue cycle. Otherwise the source waits for that producer.
- R4: `rd_grant[u]` is high for exactly one cycle per instruction on unit u, in the first cycle after issue in which both of its sources are ready. After the grant, neither source counts as a pending read.
- R5: A pulse on `exec_done[u]` is accepted only after unit u has had its read grant and before its write grant. A pulse at any other time has no effect.
- R6: A unit whose execution is complete is refused its write grant while any other occupied unit has a source equal to its destination that is marked ready and not yet read. The ready mark is the value registered at the start of the cycle.
- R7: At most one `wr_grant` bit is high per cycle, and the lowest-numbered eligible unit wins. In the cycle after a grant, the unit is free, the destination register has no pending producer, and every source that waited on that unit is ready.
- R8: After reset, every unit is free and every register has no pending producer, so no grant is given.
- R9: `iss_stall` is low whenever `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | A decoded instruction is offered for issue |
| iss_dst | input | REG_W | Destination register of the offered instruction |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_fu | input | FU_SEL_W | Functional unit that must execute the instruction |
| exec_done | input | NUM_FU | Per-unit pulse: execution finished |
| iss_stall | output | 1 | Offered instruction cannot issue this cycle |
| rd_grant | output | NUM_FU | Per-unit permission to read operands this cycle |
| wr_grant | output | NUM_FU | Per-unit permission to write the result this cycle |

## Verification
Two collisions get the closest attention. The first is a result write that falls in the same cycle as the issue of an instruction reading the register being retired. That instruction must see its source as ready and get its read grant one cycle later, with no deadlock. The second is a read grant on one unit in the same cycle as a write request from another unit whose destination that first unit is reading. The write must be held one more cycle, because the ready mark is only cleared at the following edge. Directed sequences line both cases up on exact cycles. A long random run with overlapping issues and completion pulses then checks all three outputs against a behavioural model on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_NUM_FU  = 4;
    localparam int SB_NUM_REG = 16;
endpackage

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl #(
    parameter int NUM_FU   = sb_pkg::SB_NUM_FU,
    parameter int NUM_REG  = sb_pkg::SB_NUM_REG,
    localparam int REG_W    = $clog2(NUM_REG),
    localparam int FU_SEL_W = $clog2(NUM_FU),
    localparam int TAG_W    = $clog2(NUM_FU + 1)
) (
    input  logic                             iss_valid,
    input  logic [REG_W-1:0]                 iss_dst,
    input  logic [REG_W-1:0]                 iss_src1,
    input  logic [REG_W-1:0]                 iss_src2,
    input  logic [FU_SEL_W-1:0]              iss_fu,
    input  logic [NUM_FU-1:0]                fu_busy,
    input  logic [NUM_REG-1:0][TAG_W-1:0]    rstat,
    input  logic [NUM_FU-1:0]                wr_grant,
    output logic                             iss_stall,
    output logic                             iss_fire,
    output logic [TAG_W-1:0]                 qj_new,
    output logic [TAG_W-1:0]                 qk_new,
    output logic                             rj_new,
    output logic                             rk_new
);
    logic             sel_ok;
    logic [TAG_W-1:0] wtag;
    logic [TAG_W-1:0] q1, q2;

    // A unit count that is not a power of two leaves unused select codes
    if ((1 << FU_SEL_W) == NUM_FU) begin : g_full_sel
        assign sel_ok = 1'b1;
    end else begin : g_part_sel
        assign sel_ok = (32'(iss_fu) < NUM_FU);
    end

    always_comb begin
        wtag = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (wr_grant[u]) wtag = TAG_W'(u + 1);
        end
    end

    always_comb begin
        q1     = rstat[iss_src1];
        q2     = rstat[iss_src2];
        // a producer retiring this cycle makes the source ready
        rj_new = (q1 == '0) || (q1 == wtag);
        rk_new = (q2 == '0) || (q2 == wtag);
        qj_new = rj_new ? '0 : q1;
        qk_new = rk_new ? '0 : q2;
        iss_stall = iss_valid &&
                    (!sel_ok || fu_busy[iss_fu] || (rstat[iss_dst] != '0));
        iss_fire  = iss_valid && !iss_stall;
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int NUM_FU  = sb_pkg::SB_NUM_FU,
    parameter int NUM_REG = sb_pkg::SB_NUM_REG,
    localparam int REG_W   = $clog2(NUM_REG)
) (
    input  logic [NUM_FU-1:0]             fu_busy,
    input  logic [NUM_FU-1:0]             fu_exd,
    input  logic [NUM_FU-1:0]             fu_rj,
    input  logic [NUM_FU-1:0]             fu_rk,
    input  logic [NUM_FU-1:0][REG_W-1:0]  fu_fi,
    input  logic [NUM_FU-1:0][REG_W-1:0]  fu_fj,
    input  logic [NUM_FU-1:0][REG_W-1:0]  fu_fk,
    output logic [NUM_FU-1:0]             wr_grant
);
    logic [NUM_FU-1:0] war;
    logic [NUM_FU-1:0] elig;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            war[u] = 1'b0;
            for (int v = 0; v < NUM_FU; v++) begin
                if (v != u && fu_busy[v] &&
                    ((fu_rj[v] && fu_fj[v] == fu_fi[u]) ||
                     (fu_rk[v] && fu_fk[v] == fu_fi[u])))
                    war[u] = 1'b1;
            end
            elig[u] = fu_busy[u] && fu_exd[u] && !war[u];
        end
    end

    // fixed priority: lowest index first
    always_comb begin
        logic taken;
        taken    = 1'b0;
        wr_grant = '0;
        for (int u = 0; u < NUM_FU; u++) begin
            if (elig[u] && !taken) begin
                wr_grant[u] = 1'b1;
                taken       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
    parameter int NUM_FU   = sb_pkg::SB_NUM_FU,
    parameter int NUM_REG  = sb_pkg::SB_NUM_REG,
    localparam int REG_W    = $clog2(NUM_REG),
    localparam int FU_SEL_W = $clog2(NUM_FU),
    localparam int TAG_W    = $clog2(NUM_FU + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_valid,
    input  logic [REG_W-1:0]     iss_dst,
    input  logic [REG_W-1:0]     iss_src1,
    input  logic [REG_W-1:0]     iss_src2,
    input  logic [FU_SEL_W-1:0]  iss_fu,
    input  logic [NUM_FU-1:0]    exec_done,
    output logic                 iss_stall,
    output logic [NUM_FU-1:0]    rd_grant,
    output logic [NUM_FU-1:0]    wr_grant
);
    typedef logic [TAG_W-1:0] tag_t;

    typedef struct packed {
        logic             busy;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        tag_t             qj;
        tag_t             qk;
        logic             rj;
        logic             rk;
        logic             rd_done;
        logic             ex_done;
    } fu_rec_t;

    typedef struct packed {
        fu_rec_t [NUM_FU-1:0] fu;
        tag_t [NUM_REG-1:0]   rstat;
    } sb_state_t;

    sb_state_t s_d, s_q;

    logic [NUM_FU-1:0]            busy_v, exd_v, rj_v, rk_v;
    logic [NUM_FU-1:0][REG_W-1:0] fi_a, fj_a, fk_a;
    logic                         iss_fire;
    tag_t                         qj_new, qk_new;
    logic                         rj_new, rk_new;

    always_comb begin
        for (int u = 0; u < NUM_FU; u++) begin
            busy_v[u] = s_q.fu[u].busy;
            exd_v[u]  = s_q.fu[u].ex_done;
            rj_v[u]   = s_q.fu[u].rj;
            rk_v[u]   = s_q.fu[u].rk;
            fi_a[u]   = s_q.fu[u].fi;
            fj_a[u]   = s_q.fu[u].fj;
            fk_a[u]   = s_q.fu[u].fk;
            rd_grant[u] = s_q.fu[u].busy && !s_q.fu[u].rd_done &&
                          s_q.fu[u].rj && s_q.fu[u].rk;
        end
    end

    sb_issue_ctrl #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_issue (
        .iss_valid (iss_valid),
        .iss_dst   (iss_dst),
        .iss_src1  (iss_src1),
        .iss_src2  (iss_src2),
        .iss_fu    (iss_fu),
        .fu_busy   (busy_v),
        .rstat     (s_q.rstat),
        .wr_grant  (wr_grant),
        .iss_stall (iss_stall),
        .iss_fire  (iss_fire),
        .qj_new    (qj_new),
        .qk_new    (qk_new),
        .rj_new    (rj_new),
        .rk_new    (rk_new)
    );

    sb_wb_arbiter #(.NUM_FU(NUM_FU), .NUM_REG(NUM_REG)) u_wb (
        .fu_busy  (busy_v),
        .fu_exd   (exd_v),
        .fu_rj    (rj_v),
        .fu_rk    (rk_v),
        .fu_fi    (fi_a),
        .fu_fj    (fj_a),
        .fu_fk    (fk_a),
        .wr_grant (wr_grant)
    );

    always_comb begin
        s_d = s_q;
        // operand read and execution completion
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                s_d.fu[u].rd_done = 1'b1;
                s_d.fu[u].rj      = 1'b0;
                s_d.fu[u].rk      = 1'b0;
            end
            if (exec_done[u] && s_q.fu[u].busy && s_q.fu[u].rd_done &&
                !s_q.fu[u].ex_done)
                s_d.fu[u].ex_done = 1'b1;
        end
        // result write: free unit, clear pending entry, wake waiters
        for (int w = 0; w < NUM_FU; w++) begin
            if (wr_grant[w]) begin
                s_d.fu[w] = '0;
                s_d.rstat[s_q.fu[w].fi] = '0;
                for (int v = 0; v < NUM_FU; v++) begin
                    if (s_q.fu[v].qj == tag_t'(w + 1)) begin
                        s_d.fu[v].qj = '0;
                        s_d.fu[v].rj = 1'b1;
                    end
                    if (s_q.fu[v].qk == tag_t'(w + 1)) begin
                        s_d.fu[v].qk = '0;
                        s_d.fu[v].rk = 1'b1;
                    end
                end
            end
        end
        // issue: load the unit record and claim the destination
        if (iss_fire) begin
            s_d.fu[iss_fu] = '{busy: 1'b1, fi: iss_dst, fj: iss_src1,
                               fk: iss_src2, qj: qj_new, qk: qk_new,
                               rj: rj_new, rk: rk_new, rd_done: 1'b0,
                               ex_done: 1'b0};
            s_d.rstat[iss_dst] = tag_t'(iss_fu) + tag_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // ---------------- assertions ----------------
    assert_wr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));

    assert_idle_no_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_valid |-> !iss_stall);

    assert_issue_claims_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall) |=> s_q.rstat[$past(iss_dst)] != '0);

    for (genvar g = 0; g < NUM_FU; g++) begin : g_unit_chk
        assert_rd_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |=> !rd_grant[g]);
        assert_rd_before_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[g] |-> !wr_grant[g]);
        assert_free_after_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[g] |=> !busy_v[g]);
    end
endmodule

// File: tb/sb_scoreboard_bench.sv
`timescale 1ns/1ps
module sb_scoreboard_bench;
    localparam int NF = 4;
    localparam int NR = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [3:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [1:0] iss_fu = '0;
    logic [3:0] exec_done = '0;
    logic       iss_stall;
    logic [3:0] rd_grant, wr_grant;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sb_scoreboard u_sb_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_fu(iss_fu),
        .exec_done(exec_done), .iss_stall(iss_stall),
        .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    // ---------------- behavioural reference ----------------
    int m_busy[NF], m_fi[NF], m_fj[NF], m_fk[NF], m_qj[NF], m_qk[NF];
    int m_rj[NF], m_rk[NF], m_rdd[NF], m_exd[NF];
    int m_rs[NR];

    function automatic void m_clear();
        for (int u = 0; u < NF; u++) begin
            m_busy[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
            m_qj[u] = 0; m_qk[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
            m_rdd[u] = 0; m_exd[u] = 0;
        end
        for (int r = 0; r < NR; r++) m_rs[r] = 0;
    endfunction

    function automatic void predict(output int st, output logic [3:0] rd,
                                    output logic [3:0] wr);
        int winner;
        winner = -1;
        for (int u = 0; u < NF; u++) begin
            int blocked;
            blocked = 0;
            for (int v = 0; v < NF; v++)
                if (v != u && m_busy[v] != 0 &&
                    ((m_rj[v] != 0 && m_fj[v] == m_fi[u]) ||
                     (m_rk[v] != 0 && m_fk[v] == m_fi[u]))) blocked = 1;
            if (winner < 0 && m_busy[u] != 0 && m_exd[u] != 0 && blocked == 0)
                winner = u;
            rd[u] = (m_busy[u] != 0 && m_rdd[u] == 0 && m_rj[u] != 0 && m_rk[u] != 0);
        end
        wr = '0;
        if (winner >= 0) wr[winner] = 1'b1;
        st = (iss_valid && (m_busy[iss_fu] != 0 || m_rs[iss_dst] != 0)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_clear();
        else begin
            int st; logic [3:0] rd, wr; int wtag;
            predict(st, rd, wr);
            wtag = 0;
            for (int u = 0; u < NF; u++) begin
                if (rd[u]) begin m_rdd[u] = 1; m_rj[u] = 0; m_rk[u] = 0; end
                else if (exec_done[u] && m_busy[u] != 0 && m_rdd[u] != 0) m_exd[u] = 1;
            end
            for (int w = 0; w < NF; w++) if (wr[w]) begin
                wtag = w + 1;
                m_rs[m_fi[w]] = 0;
                m_busy[w] = 0; m_rdd[w] = 0; m_exd[w] = 0;
                m_fi[w] = 0; m_fj[w] = 0; m_fk[w] = 0;
                for (int v = 0; v < NF; v++) begin
                    if (m_qj[v] == wtag) begin m_qj[v] = 0; m_rj[v] = 1; end
                    if (m_qk[v] == wtag) begin m_qk[v] = 0; m_rk[v] = 1; end
                end
            end
            if (iss_valid && st == 0) begin
                int a, b;
                a = m_rs[iss_src1]; b = m_rs[iss_src2];
                if (a == wtag) a = 0;
                if (b == wtag) b = 0;
                m_busy[iss_fu] = 1; m_fi[iss_fu] = iss_dst;
                m_fj[iss_fu] = iss_src1; m_fk[iss_fu] = iss_src2;
                m_qj[iss_fu] = a; m_qk[iss_fu] = b;
                m_rj[iss_fu] = (a == 0); m_rk[iss_fu] = (b == 0);
                m_rdd[iss_fu] = 0; m_exd[iss_fu] = 0;
                m_rs[iss_dst] = iss_fu + 1;
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
        end
    endtask

    // compare against the reference every cycle, away from the edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            int st; logic [3:0] rd, wr;
            predict(st, rd, wr);
            chk("iss_stall (R1,R2,R3,R9)", int'(iss_stall), st);
            chk("rd_grant (R4,R5)", int'(rd_grant), int'(rd));
            chk("wr_grant (R6,R7)", int'(wr_grant), int'(wr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic go();
        @(negedge clk);
        iss_valid = 1'b0;
        exec_done = '0;
    endtask

    task automatic issue(int fu, int d, int s1, int s2);
        iss_valid = 1'b1;
        iss_fu = 2'(fu); iss_dst = 4'(d); iss_src1 = 4'(s1); iss_src2 = 4'(s2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R8: reset state, stray completion pulses change nothing; R9 idle
        go(); exec_done = 4'b1111; #1;
        chk("R8 no read grant after reset", int'(rd_grant), 0);
        chk("R9 no stall while idle", int'(iss_stall), 0);
        go(); #1;
        chk("R8 no write grant after reset", int'(wr_grant), 0);

        // load then dependent add (R3, R4, R7)
        go(); issue(0, 1, 2, 3); #1;
        chk("R3 load accepted", int'(iss_stall), 0);
        go(); issue(1, 4, 1, 5); #1;
        chk("R4 load reads", int'(rd_grant[0]), 1);
        chk("R3 dependent add accepted", int'(iss_stall), 0);
        go(); exec_done = 4'b0001; #1;
        chk("R3 add waits for load", int'(rd_grant[1]), 0);
        chk("R4 load read only once", int'(rd_grant[0]), 0);
        go(); #1;
        chk("R7 load writes", int'(wr_grant), 4'b0001);
        go(); #1;
        chk("R7 add woken", int'(rd_grant), 4'b0010);
        go(); exec_done = 4'b0010;
        go(); #1;
        chk("R7 add writes", int'(wr_grant), 4'b0010);
        go();

        // structural then write-after-write stall (R1, R2)
        go(); issue(2, 6, 7, 8); #1;
        chk("R1 free unit accepts", int'(iss_stall), 0);
        go(); issue(2, 9, 7, 8); #1;
        chk("R1 busy unit stalls", int'(iss_stall), 1);
        go(); issue(2, 9, 7, 8); exec_done = 4'b0100; #1;
        chk("R1 still busy", int'(iss_stall), 1);
        go(); issue(2, 9, 7, 8); #1;
        chk("R1 write cycle still stalls", int'(iss_stall), 1);
        chk("R7 unit two writes", int'(wr_grant), 4'b0100);
        go(); issue(2, 9, 7, 8); #1;
        chk("R1 stall released", int'(iss_stall), 0);
        go(); issue(3, 9, 7, 8); #1;
        chk("R2 same destination stalls", int'(iss_stall), 1);
        go(); issue(3, 9, 7, 8); exec_done = 4'b0100; #1;
        chk("R2 still pending", int'(iss_stall), 1);
        go(); issue(3, 9, 7, 8); #1;
        chk("R2 producer write cycle stalls", int'(iss_stall), 1);
        go(); issue(3, 9, 7, 8); #1;
        chk("R2 stall released", int'(iss_stall), 0);
        go(); #1;
        chk("R4 unit three reads", int'(rd_grant[3]), 1);
        go(); exec_done = 4'b1000;
        go(); #1;
        chk("R7 unit three writes", int'(wr_grant), 4'b1000);
        go();

        // early completion ignored, same-cycle write and issue, priority (R3, R5, R7)
        go(); issue(0, 11, 2, 3);
        go(); issue(3, 12, 11, 2);
        go(); exec_done = 4'b1001; #1;
        chk("R3 consumer of r11 waits", int'(rd_grant[3]), 0);
        go(); issue(1, 13, 11, 2); #1;
        chk("R7 producer of r11 writes", int'(wr_grant), 4'b0001);
        chk("R3 issue during producer write", int'(iss_stall), 0);
        go(); #1;
        chk("R3 both consumers read", int'(rd_grant), 4'b1010);
        go(); #1;
        chk("R5 early pulse had no effect", int'(wr_grant), 0);
        go(); exec_done = 4'b1010;
        go(); #1;
        chk("R7 lower index wins", int'(wr_grant), 4'b0010);
        go(); #1;
        chk("R7 higher index next", int'(wr_grant), 4'b1000);
        go();

        // write-after-read hold (R6)
        go(); issue(0, 13, 2, 3);
        go(); issue(1, 14, 12, 13);
        go(); issue(2, 12, 4, 5); #1;
        chk("R6 reader of r12 parked, writer accepted", int'(iss_stall), 0);
        go();
        go(); exec_done = 4'b0100;
        go(); #1;
        chk("R6 write held by pending read", int'(wr_grant), 0);
        go(); exec_done = 4'b0001; #1;
        chk("R6 write still held", int'(wr_grant), 0);
        go(); #1;
        chk("R6 unrelated writer proceeds", int'(wr_grant), 4'b0001);
        go(); #1;
        chk("R6 reader reads", int'(rd_grant), 4'b0010);
        chk("R6 held during read cycle", int'(wr_grant), 0);
        go(); #1;
        chk("R6 write released", int'(wr_grant), 4'b0100);
        go(); exec_done = 4'b0010;
        go(); #1;
        chk("R7 reader writes", int'(wr_grant), 4'b0010);

        // random traffic, judged by the reference each cycle
        for (int i = 0; i < 4000; i++) begin
            go();
            if ($urandom_range(0, 1) == 1)
                issue($urandom_range(0, 3), $urandom_range(0, 7),
                      $urandom_range(0, 7), $urandom_range(0, 7));
            exec_done = 4'($urandom_range(0, 15));
        end
        for (int i = 0; i < 100; i++) begin
            go(); exec_done = 4'b1111;
        end
        go(); #1;
        chk("R7 all units drained", int'(rd_grant | wr_grant), 0);
        finish_run();
    end
endmodule